// File: doc/BRIEF.md
# Aliased Baud/Frame-Control Register Front End

This block is the register-file front end of a serial port in which two registers sit behind a single bus address. One is the upper part of the baud-rate divisor. The other is the frame-control register. A write to that address is steered by the most significant bit of the write data. When that bit is one the control register takes the data. When it is zero the baud-rate high register takes it.

Reads of the shared address follow a timed rule. A lone read returns the baud-rate high register. A read issued in the clock cycle directly after another read of the same address returns the control register instead. Only a read in the immediately preceding cycle arms this second response. An idle cycle, a write cycle or a read of any other address clears it.

Software that wants the control register therefore issues two back-to-back reads. Software that reads the address once gets the baud byte. Both register values are also driven out on dedicated outputs, which feed the baud generator and the serial engines.

Top module: `alias_regs`

## Requirements
- R1: After reset, `ctrl_out` is 8'h86, `baud_hi_out` is 0 and `rd_data` is 0. The read sequence starts disarmed, so the first shared read after reset returns the baud byte.
- R2: A write cycle (`wr_en`=1) to `SHARED_ADDR` (default 3) with `wr_data[7]`=1 loads `wr_data[6:0]` into `ctrl_out[6:0]` at the next clock edge and leaves `baud_hi_out` unchanged.
- R3: A write cycle to `SHARED_ADDR` with `wr_data[7]`=0 loads `wr_data[BAUD_W-1:0]` into `baud_hi_out` at the next clock edge and leaves `ctrl_out` unchanged.
- R4: A read of `SHARED_ADDR` (`rd_en`=1) is a "first read" when the previous cycle was not also a read of `SHARED_ADDR`. A first read returns the baud-rate high register, zero-extended to 8 bits. With the default registered read port the value appears on `rd_data` one cycle after the read cycle.
- R5: A read of `SHARED_ADDR` in the cycle directly after another read of `SHARED_ADDR` returns the control register, with the same latency. Bit 7 of that value is always one, and `ctrl_out[7]` is always one. This holds for every further read in an unbroken run of shared reads.
- R6: Any of the following between two shared reads makes the later read a first read again: an idle cycle, a write-only cycle, or a read of another address.
- R7: A read of any address other than `SHARED_ADDR` returns 0. In a cycle following one with `rd_en`=0, `rd_data` is 0.
- R8: A write to any address other than `SHARED_ADDR` changes neither `ctrl_out` nor `baud_hi_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Bus address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | DATA_W | Write data; the top bit selects the target register |
| rd_data | output | DATA_W | Read data (registered by default) |
| ctrl_out | output | DATA_W | Frame-control register, top bit always one |
| baud_hi_out | output | BAUD_W | Baud-rate divisor high bits |

## Verification
Suppose the one-bit sequence flag is stuck or set wrongly. The very next shared read then returns the wrong register on `rd_data` one cycle later: a control byte with bit 7 set where a baud byte with its upper bits clear was expected, or the reverse. These two values cannot be confused. A mis-steered write shows on `ctrl_out` or `baud_hi_out` one edge after the write. Every written value is swept and read back through both a single read and a paired read, so an error in steering or in the sequence flag surfaces within a few cycles.

// File: rtl/alias_regs_pkg.sv
package alias_regs_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_BAUD = 2'd1,
      SRC_CTRL = 2'd2
   } rd_src_e;
endpackage

// File: rtl/alias_wr_steer.sv
module alias_wr_steer #(
   parameter int              ADDR_W      = 4,
   parameter int              DATA_W      = 8,
   parameter int              BAUD_W      = 4,
   parameter logic [ADDR_W-1:0] SHARED_ADDR = 3,
   parameter logic [DATA_W-1:0] CTRL_RST  = 8'h86
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [BAUD_W-1:0] baud_q
);
   localparam int SEL = DATA_W - 1;

   logic              hit_wr;
   logic [SEL-1:0]    ctrl_low;

   assign hit_wr = wr_en && (addr == SHARED_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_low <= CTRL_RST[SEL-1:0];
         baud_q   <= '0;
      end else if (hit_wr) begin
         if (wr_data[SEL])
            ctrl_low <= wr_data[SEL-1:0];
         else
            baud_q   <= wr_data[BAUD_W-1:0];
      end
   end

   assign ctrl_q = {1'b1, ctrl_low};
endmodule

// File: rtl/alias_rd_seq.sv
module alias_rd_seq #(
   parameter int              ADDR_W      = 4,
   parameter logic [ADDR_W-1:0] SHARED_ADDR = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   rd_en,
   output alias_regs_pkg::rd_src_e src
);
   import alias_regs_pkg::*;

   logic hit_rd;
   logic armed_q;

   assign hit_rd = rd_en && (addr == SHARED_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= hit_rd;
   end

   always_comb begin
      if (!hit_rd)      src = SRC_NONE;
      else if (armed_q) src = SRC_CTRL;
      else              src = SRC_BAUD;
   end
endmodule

// File: rtl/alias_rd_port.sv
module alias_rd_port #(
   parameter int DATA_W    = 8,
   parameter int BAUD_W    = 4,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  alias_regs_pkg::rd_src_e src,
   input  logic [DATA_W-1:0]       ctrl_q,
   input  logic [BAUD_W-1:0]       baud_q,
   output logic [DATA_W-1:0]       rd_data
);
   import alias_regs_pkg::*;

   localparam int PAD_W = DATA_W - BAUD_W;

   logic [DATA_W-1:0] mux_d;

   always_comb begin
      case (src)
         SRC_CTRL: mux_d = ctrl_q;
         SRC_BAUD: mux_d = {{PAD_W{1'b0}}, baud_q};
         default:  mux_d = '0;
      endcase
   end

   generate
      if (REG_RDATA) begin : g_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= mux_d;
         end
         assign rd_data = rd_q;
      end else begin : g_comb
         assign rd_data = mux_d;
      end
   endgenerate
endmodule

// File: rtl/alias_regs.sv
module alias_regs #(
   parameter int              ADDR_W      = 4,
   parameter int              DATA_W      = 8,
   parameter int              BAUD_W      = 4,
   parameter logic [ADDR_W-1:0] SHARED_ADDR = 3,
   parameter logic [DATA_W-1:0] CTRL_RST  = 8'h86,
   parameter bit              REG_RDATA   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] ctrl_out,
   output logic [BAUD_W-1:0] baud_hi_out
);
   import alias_regs_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("alias_regs: DATA_W must be at least 2");
      end
      if (BAUD_W < 1 || BAUD_W > DATA_W - 1) begin : g_bad_baud
         $error("alias_regs: BAUD_W must lie in 1..DATA_W-1");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("alias_regs: ADDR_W must be at least 1");
      end
   endgenerate

   rd_src_e src;

   alias_wr_steer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BAUD_W(BAUD_W),
      .SHARED_ADDR(SHARED_ADDR), .CTRL_RST(CTRL_RST)
   ) u_steer (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .ctrl_q(ctrl_out), .baud_q(baud_hi_out)
   );

   alias_rd_seq #(
      .ADDR_W(ADDR_W), .SHARED_ADDR(SHARED_ADDR)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .src(src)
   );

   alias_rd_port #(
      .DATA_W(DATA_W), .BAUD_W(BAUD_W), .REG_RDATA(REG_RDATA)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .src(src), .ctrl_q(ctrl_out),
      .baud_q(baud_hi_out), .rd_data(rd_data)
   );
endmodule

// File: rtl/alias_regs_chk.sv
module alias_regs_chk #(
   parameter int              ADDR_W      = 4,
   parameter int              DATA_W      = 8,
   parameter int              BAUD_W      = 4,
   parameter logic [ADDR_W-1:0] SHARED_ADDR = 3,
   parameter bit              REG_RDATA   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] ctrl_out,
   input logic [BAUD_W-1:0] baud_hi_out
);
   localparam int PAD_W = DATA_W - BAUD_W;

   logic hit_r, hit_w, prev_hit;
   logic [DATA_W-1:0] baud_ext;

   assign hit_r    = rd_en && (addr == SHARED_ADDR);
   assign hit_w    = wr_en && (addr == SHARED_ADDR);
   assign baud_ext = {{PAD_W{1'b0}}, baud_hi_out};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_hit <= 1'b0;
      else        prev_hit <= hit_r;
   end

   AST_CTRL_TOP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_out[DATA_W-1]);                                                    // R5
   AST_BAUD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_w && !wr_data[DATA_W-1]) |=> $stable(baud_hi_out));               // R3
   AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_w && wr_data[DATA_W-1]) |=> $stable(ctrl_out));                   // R2

   generate
      if (REG_RDATA) begin : g_reg_chk
         AST_FIRST_READ_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_r && !prev_hit) |=> rd_data == $past(baud_ext));             // R4
         AST_SECOND_READ_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_r && prev_hit) |=> rd_data == $past(ctrl_out));              // R5
         AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_en || addr != SHARED_ADDR) |=> rd_data == '0);               // R7
      end else begin : g_comb_chk
         AST_FIRST_READ_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_r && !prev_hit) |-> rd_data == baud_ext);                    // R4
         AST_SECOND_READ_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_r && prev_hit) |-> rd_data == ctrl_out);                     // R5
         AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !hit_r |-> rd_data == '0);                                        // R7
      end
   endgenerate
endmodule

bind alias_regs alias_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BAUD_W(BAUD_W),
   .SHARED_ADDR(SHARED_ADDR), .REG_RDATA(REG_RDATA)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .wr_data(wr_data), .rd_data(rd_data), .ctrl_out(ctrl_out),
   .baud_hi_out(baud_hi_out)
);

// File: tb/alias_regs_tb.sv
module alias_regs_tb;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam int BAUD_W = 4;
   localparam logic [ADDR_W-1:0] SH = 4'd3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] ctrl_out;
   logic [BAUD_W-1:0] baud_hi_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [DATA_W-1:0] m_ctrl;
   logic [BAUD_W-1:0] m_baud;

   always #10 clk = ~clk;

   alias_regs u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .ctrl_out(ctrl_out),
      .baud_hi_out(baud_hi_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one bus cycle; on return, outputs reflect this cycle
   task automatic cyc(input logic [ADDR_W-1:0] a, input logic w, input logic r,
                      input logic [DATA_W-1:0] d);
      addr = a; wr_en = w; rd_en = r; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
   endtask

   function automatic logic [DATA_W-1:0] baud_ext();
      return {{(DATA_W-BAUD_W){1'b0}}, m_baud};
   endfunction

   task automatic model_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      if (a == SH) begin
         if (d[7]) m_ctrl = {1'b1, d[6:0]};
         else      m_baud = d[BAUD_W-1:0];
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_ctrl = 8'h86;
      m_baud = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ctrl reset", ctrl_out, 8'h86);
      check("R1 baud reset", baud_hi_out, 0);
      check("R1 rd_data reset", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc(SH, 0, 1, 0);
      check("R1 first read after reset is baud", rd_data, 0);

      // Exhaustive write sweep with single/paired/broken reads
      for (int v = 0; v < 256; v++) begin
         cyc(SH, 1, 0, v[7:0]);
         model_write(SH, v[7:0]);
         if (v[7]) check("R2 ctrl write", ctrl_out, m_ctrl);
         else      check("R3 baud write", baud_hi_out, m_baud);
         check("R2 R3 other reg kept", {ctrl_out, baud_hi_out}, {m_ctrl, m_baud});
         cyc(SH, 0, 1, 0);
         check("R4 single read baud", rd_data, baud_ext());
         cyc(SH, 0, 1, 0);
         check("R5 paired read ctrl", rd_data, m_ctrl);
         check("R5 ctrl top bit", rd_data[7], 1'b1);
         cyc(SH, 0, 1, 0);
         check("R5 run continues ctrl", rd_data, m_ctrl);
         case (v % 3)
            0: begin cyc(SH, 0, 0, 0); check("R7 idle zero", rd_data, 0); end
            1: begin cyc(SH, 1, 0, 8'h00 | m_baud); check("R7 write-only zero", rd_data, 0); end
            default: begin cyc(4'(v % 16 == 3 ? 4 : v % 16), 0, 1, 0);
                           check("R7 other read zero", rd_data, 0); end
         endcase
         cyc(SH, 0, 1, 0);
         check("R6 break rearms baud", rd_data, baud_ext());
      end

      // R8: writes to every other address ignored, read back at ports
      for (int a = 0; a < 16; a++) begin
         if (a != SH) begin
            cyc(a[ADDR_W-1:0], 1, 0, 8'hFF);
            cyc(a[ADDR_W-1:0], 1, 0, 8'h0A);
            check("R8 ctrl unchanged", ctrl_out, m_ctrl);
            check("R8 baud unchanged", baud_hi_out, m_baud);
            cyc(a[ADDR_W-1:0], 0, 1, 0);
            check("R7 other address reads zero", rd_data, 0);
            cyc(SH, 0, 1, 0);
            check("R6 other read then shared is baud", rd_data, baud_ext());
         end
      end

      // R6: shared read after other-address read pair stays baud
      cyc(SH, 0, 1, 0);
      cyc(4'd5, 0, 1, 0);
      cyc(SH, 0, 1, 0);
      check("R6 interleaved read baud", rd_data, baud_ext());

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule